// File: doc/BRIEF.md
# Palette Lookup and Direct-Colour Pixel Converter

This block turns a stream of 16-bit frame-buffer words into a stream of per-pixel red, green and blue codes ready for a video DAC. A 3-bit depth selector picks one of five pixel formats: 4-bit grey, 4-bit indexed colour, 8-bit indexed colour, and two direct-colour layouts (5-5-5 and 5-6-5).

In the indexed and grey formats each pixel is an address into three 256-entry, 4-bit palette RAMs, one per colour. A host loads these through a small write port. In the direct formats the palette is skipped and the channel fields are sliced straight out of the word. Every channel leaves the block at a common width. A narrow code is widened by repeating its bits from the most significant end.

A word carries four, two or one pixel(s), depending on the format. The block takes a new word only when the current one is nearly drained, so that pixels leave one per cycle without gaps.

Top module: `pcp_top`

## Requirements
- R1: After reset `out_vld` is 0 and `in_rdy` is 1.
- R2: Grey mode (code 0) splits each word into four 4-bit pixels, lowest nibble first. The green output is the green palette entry at the nibble's address, widened. The red and blue outputs are 0.
- R3: Indexed-4 mode (code 1) splits each word into four nibbles, lowest first. Each nibble addresses entries 0x0 to 0xF of all three palettes. Each 4-bit entry c is output as {c,c}.
- R4: Indexed-8 mode (code 2) splits each word into two bytes, lowest first. Each byte addresses all 256 entries of each palette. The outputs are widened as in R3.
- R5: 5-5-5 mode (code 3) gives one pixel per word: blue is bits [4:0], green is bits [9:5] and red is bits [14:10]. Bit 15 is ignored. A 5-bit field v is output as {v, v[4:2]}.
- R6: 5-6-5 mode (code 4) gives one pixel per word: blue is bits [4:0], green is bits [10:5] and red is bits [15:11]. A 6-bit field g is output as {g, g[5:4]}.
- R7: A word is accepted on a clock edge where `in_vld` and `in_rdy` are both 1. `in_rdy` is 0 while more than one pixel of the current word remains. With `in_vld` held high, a 4-pixel word is followed by the next word four cycles later, and a direct word by the next word one cycle later.
- R8: The first pixel of a word accepted at edge k is on the outputs with `out_vld`=1 after edge k+1. The following pixels of that word appear one per cycle after that.
- R9: A palette write (`pal_we`=1; `pal_chan` 0=red, 1=green, 2=blue) takes effect at its clock edge and is seen by every lookup made at a later edge. A write with `pal_chan`=3 changes no palette.
- R10: The depth code is sampled together with the word. Changing `mode` while a word is still draining does not alter that word's pixels.
- R11: A word accepted under an unused code (5 to 7) is discarded. No pixel is produced, and `in_rdy` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Depth code, sampled with each accepted word |
| in_vld | input | 1 | Frame-buffer word valid |
| in_word | input | 16 | Frame-buffer word |
| in_rdy | output | 1 | Block can take a word this cycle |
| pal_we | input | 1 | Palette write strobe |
| pal_chan | input | 2 | Palette select: 0 red, 1 green, 2 blue, 3 none |
| pal_addr | input | 8 | Palette entry address |
| pal_data | input | 4 | Palette entry value |
| out_vld | output | 1 | Pixel output valid |
| out_r | output | 8 | Red code |
| out_g | output | 8 | Green code |
| out_b | output | 8 | Blue code |

## Verification
Pixel 0 of a word accepted at edge k is due on the outputs after edge k+1, and pixel i is due after edge k+1+i. The bench drives inputs on falling edges and counts rising edges from the acceptance edge. It samples each pixel on the falling edge that follows the rising edge where that pixel is due. The `in_rdy` drop and rise for R7 are read on the same falling edges, at fixed offsets from the acceptance edge. A palette write is made at least one edge before the lookup that must see it.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

   typedef enum logic [2:0] {
      PM_GREY4 = 3'd0,
      PM_IDX4  = 3'd1,
      PM_IDX8  = 3'd2,
      PM_D555  = 3'd3,
      PM_D565  = 3'd4
   } pmode_e;

   localparam int CHANS = 3;

   // Repeat a w-bit code cyclically from its MSB to fill ow bits.
   function automatic logic [15:0] spread(input logic [15:0] v, input int w, input int ow);
      logic [15:0] r;
      r = '0;
      for (int i = 0; i < 16; i++) begin
         if (i < ow) r[ow-1-i] = v[w-1-(i % w)];
      end
      return r;
   endfunction

endpackage

// File: rtl/pcp_unpack.sv
module pcp_unpack
   import pcp_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              in_vld,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_rdy,
   output logic              px_vld,
   output logic [2:0]        px_mode,
   output logic [WORD_W-1:0] px_word
);
   localparam int N4 = WORD_W / 4;
   localparam int N8 = WORD_W / 8;
   localparam int CW = $clog2(N4 + 1);

   logic [CW-1:0]     rem_q;
   logic [WORD_W-1:0] word_q;
   logic [2:0]        mode_q;
   logic [CW-1:0]     load_cnt;
   logic              acc;
   int                shamt;

   assign in_rdy  = (rem_q <= CW'(1));
   assign acc     = in_vld && in_rdy;
   assign px_vld  = (rem_q != '0);
   assign px_mode = mode_q;
   assign px_word = word_q;

   always_comb begin
      case (pmode_e'(mode_i))
         PM_GREY4, PM_IDX4: load_cnt = CW'(N4);
         PM_IDX8:           load_cnt = CW'(N8);
         PM_D555, PM_D565:  load_cnt = CW'(1);
         default:           load_cnt = '0;
      endcase
   end

   always_comb begin
      case (pmode_e'(mode_q))
         PM_GREY4, PM_IDX4: shamt = 4;
         PM_IDX8:           shamt = 8;
         default:           shamt = WORD_W;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         word_q <= '0;
         mode_q <= '0;
      end else if (acc) begin
         word_q <= in_word;
         mode_q <= mode_i;
         rem_q  <= load_cnt;
      end else if (rem_q != '0) begin
         word_q <= (shamt >= WORD_W) ? '0 : (word_q >> shamt);
         rem_q  <= rem_q - CW'(1);
      end
   end

   // R7: a direct word drains in one cycle, so the port is free again
   p_direct_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (mode_i == 3'd3 || mode_i == 3'd4)) |=> in_rdy);

   // R7: a four-pixel word blocks the next word
   p_four_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (mode_i == 3'd0 || mode_i == 3'd1)) |=> !in_rdy);

   // R11: unused codes produce nothing and leave the port free
   p_unused_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mode_i > 3'd4) |=> (in_rdy && !px_vld));

endmodule

// File: rtl/pcp_palette.sv
module pcp_palette
   import pcp_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int LUT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       chan,
   input  logic [IDX_W-1:0] waddr,
   input  logic [LUT_W-1:0] wdata,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] raddr,
   output logic [LUT_W-1:0] rdata [CHANS]
);
   localparam int DEPTH = 1 << IDX_W;

   for (genvar c = 0; c < CHANS; c++) begin : g_chan
      logic [LUT_W-1:0] mem [DEPTH];
      logic [LUT_W-1:0] q;

      always_ff @(posedge clk) begin
         if (we && chan == 2'(c)) mem[waddr] <= wdata;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)     q <= '0;
         else if (rd_en) q <= mem[raddr];
      end

      assign rdata[c] = q;
   end

endmodule

// File: rtl/pcp_direct.sv
module pcp_direct
   import pcp_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int OUT_W  = 8
) (
   input  logic [2:0]        mode_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [OUT_W-1:0]  r_o,
   output logic [OUT_W-1:0]  g_o,
   output logic [OUT_W-1:0]  b_o
);
   logic [15:0] w16;
   logic [15:0] rs, gs, bs;

   assign w16 = 16'(word_i);

   always_comb begin
      bs = spread({11'd0, w16[4:0]}, 5, OUT_W);
      if (pmode_e'(mode_i) == PM_D565) begin
         rs = spread({11'd0, w16[15:11]}, 5, OUT_W);
         gs = spread({10'd0, w16[10:5]}, 6, OUT_W);
      end else begin
         rs = spread({11'd0, w16[14:10]}, 5, OUT_W);
         gs = spread({11'd0, w16[9:5]}, 5, OUT_W);
      end
   end

   assign r_o = rs[OUT_W-1:0];
   assign g_o = gs[OUT_W-1:0];
   assign b_o = bs[OUT_W-1:0];

endmodule

// File: rtl/pcp_top.sv
module pcp_top
   import pcp_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int IDX_W  = 8,
   parameter int LUT_W  = 4,
   parameter int OUT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              in_vld,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_rdy,
   input  logic              pal_we,
   input  logic [1:0]        pal_chan,
   input  logic [IDX_W-1:0]  pal_addr,
   input  logic [LUT_W-1:0]  pal_data,
   output logic              out_vld,
   output logic [OUT_W-1:0]  out_r,
   output logic [OUT_W-1:0]  out_g,
   output logic [OUT_W-1:0]  out_b
);
   localparam int NIB_W = 4;

   if (WORD_W != 16) begin : g_bad_word
      $error("pcp_top: WORD_W must be 16 for two-byte direct pixels");
   end
   if (IDX_W != 8) begin : g_bad_idx
      $error("pcp_top: IDX_W must be 8 for byte-wide indices");
   end
   if (LUT_W > OUT_W || OUT_W < 6 || OUT_W > 16) begin : g_bad_out
      $error("pcp_top: OUT_W must lie in 6..16 and be at least LUT_W");
   end

   logic              px_vld;
   logic [2:0]        px_mode;
   logic [WORD_W-1:0] px_word;
   logic [IDX_W-1:0]  px_idx;
   logic [LUT_W-1:0]  lut_q [CHANS];
   logic [OUT_W-1:0]  dr, dg, db;
   logic [OUT_W-1:0]  dr_q, dg_q, db_q;
   logic [2:0]        mode_p;
   logic              vld_p;
   logic [15:0]       wr, wg, wb;

   pcp_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_vld(in_vld),
      .in_word(in_word), .in_rdy(in_rdy), .px_vld(px_vld),
      .px_mode(px_mode), .px_word(px_word)
   );

   assign px_idx = (pmode_e'(px_mode) == PM_IDX8) ? px_word[IDX_W-1:0]
                                                 : IDX_W'(px_word[NIB_W-1:0]);

   pcp_palette #(.IDX_W(IDX_W), .LUT_W(LUT_W)) u_pal (
      .clk(clk), .rst_n(rst_n), .we(pal_we), .chan(pal_chan),
      .waddr(pal_addr), .wdata(pal_data), .rd_en(px_vld),
      .raddr(px_idx), .rdata(lut_q)
   );

   pcp_direct #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_direct (
      .mode_i(px_mode), .word_i(px_word), .r_o(dr), .g_o(dg), .b_o(db)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_p  <= 1'b0;
         mode_p <= '0;
         dr_q   <= '0;
         dg_q   <= '0;
         db_q   <= '0;
      end else begin
         vld_p <= px_vld;
         if (px_vld) begin
            mode_p <= px_mode;
            dr_q   <= dr;
            dg_q   <= dg;
            db_q   <= db;
         end
      end
   end

   assign wr = spread(16'(lut_q[0]), LUT_W, OUT_W);
   assign wg = spread(16'(lut_q[1]), LUT_W, OUT_W);
   assign wb = spread(16'(lut_q[2]), LUT_W, OUT_W);

   always_comb begin
      case (pmode_e'(mode_p))
         PM_GREY4: begin
            out_r = '0;
            out_g = wg[OUT_W-1:0];
            out_b = '0;
         end
         PM_IDX4, PM_IDX8: begin
            out_r = wr[OUT_W-1:0];
            out_g = wg[OUT_W-1:0];
            out_b = wb[OUT_W-1:0];
         end
         default: begin
            out_r = dr_q;
            out_g = dg_q;
            out_b = db_q;
         end
      endcase
   end

   assign out_vld = vld_p;

   // R8: every pixel presented by the unpacker shows up one cycle later
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      px_vld |=> out_vld);

   // R8: no output without a pixel in the previous cycle
   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !px_vld |=> !out_vld);

   // R2: grey pixels leave red and blue at zero
   p_grey_rb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (px_vld && px_mode == 3'd0) |=> (out_r == '0 && out_b == '0));

   // R5: bit 15 plays no part in a 5-5-5 pixel
   p_d555_top_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (px_vld && px_mode == 3'd3 && px_word[14:0] == '0) |=>
         (out_r == '0 && out_g == '0 && out_b == '0));

endmodule

// File: tb/sim_pcp_top.sv
module sim_pcp_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic        in_vld = 1'b0;
   logic [15:0] in_word = '0;
   logic        in_rdy;
   logic        pal_we = 1'b0;
   logic [1:0]  pal_chan = '0;
   logic [7:0]  pal_addr = '0;
   logic [3:0]  pal_data = '0;
   logic        out_vld;
   logic [7:0]  out_r, out_g, out_b;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   pcp_top u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .in_vld(in_vld),
      .in_word(in_word), .in_rdy(in_rdy), .pal_we(pal_we),
      .pal_chan(pal_chan), .pal_addr(pal_addr), .pal_data(pal_data),
      .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   // Palette contents loaded by the bench: red[a]=a[3:0], green[a]=~a[3:0], blue[a]=a[7:4].
   // Vector fields: {mode, word, pixel count, p0, p1, p2, p3} with p = {r,g,b}.
   localparam int NV = 11;
   localparam logic [117:0] TBL [NV] = '{
      {3'd0, 16'h3A5F, 3'd4, 24'h000000, 24'h00AA00, 24'h005500, 24'h00CC00}, // R2
      {3'd1, 16'h1C70, 3'd4, 24'h00FF00, 24'h778800, 24'hCC3300, 24'h11EE00}, // R3
      {3'd2, 16'hA53C, 3'd2, 24'hCC3333, 24'h55AAAA, 24'h0,      24'h0},      // R4
      {3'd3, 16'hFFFF, 3'd1, 24'hFFFFFF, 24'h0, 24'h0, 24'h0},               // R5
      {3'd3, 16'h8000, 3'd1, 24'h000000, 24'h0, 24'h0, 24'h0},               // R5 bit 15
      {3'd3, 16'h7C00, 3'd1, 24'hFF0000, 24'h0, 24'h0, 24'h0},               // R5
      {3'd3, 16'h0210, 3'd1, 24'h008484, 24'h0, 24'h0, 24'h0},               // R5
      {3'd3, 16'h0420, 3'd1, 24'h080800, 24'h0, 24'h0, 24'h0},               // R5
      {3'd4, 16'h07E0, 3'd1, 24'h00FF00, 24'h0, 24'h0, 24'h0},               // R6
      {3'd4, 16'hF81F, 3'd1, 24'hFF00FF, 24'h0, 24'h0, 24'h0},               // R6
      {3'd4, 16'h0420, 3'd1, 24'h008600, 24'h0, 24'h0, 24'h0}                // R6
   };

   task automatic chk(input string req, input logic [24:0] act, input logic [24:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [24:0] obs();
      return {out_vld, out_r, out_g, out_b};
   endfunction

   task automatic pal_write(input logic [1:0] ch, input logic [7:0] a, input logic [3:0] d);
      @(negedge clk);
      pal_we = 1'b1; pal_chan = ch; pal_addr = a; pal_data = d;
      @(posedge clk);
      @(negedge clk);
      pal_we = 1'b0;
   endtask

   // Send one word, then check n pixels (due after edges k+1 .. k+n).
   task automatic run_word(input string req, input logic [2:0] m, input logic [15:0] w,
                           input int n, input logic [95:0] exp, input logic [2:0] m_after);
      @(negedge clk);
      mode = m; in_word = w; in_vld = 1'b1;
      @(posedge clk);               // edge k: accept
      @(negedge clk);
      in_vld = 1'b0;
      mode = m_after;               // R10: late change must not matter
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         chk(req, obs(), {1'b1, exp[95-24*i -: 24]});
      end
      @(posedge clk);
      @(negedge clk);
      chk({req, " idle after word"}, {24'd0, out_vld}, 25'd0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 out_vld", {24'd0, out_vld}, 25'd0);
      chk("R1 in_rdy", {24'd0, in_rdy}, 25'd1);
      rst_n = 1'b1;

      // Load palettes
      for (int a = 0; a < 256; a++) begin
         for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            pal_we = 1'b1; pal_chan = 2'(c); pal_addr = 8'(a);
            pal_data = (c == 0) ? 4'(a) : (c == 1) ? ~4'(a) : 4'(a >> 4);
         end
      end
      @(negedge clk);
      pal_we = 1'b0;

      // Vector table walk (R2-R6, R8, R10)
      for (int v = 0; v < NV; v++) begin
         run_word("R2-6/R8/R10 table", TBL[v][117:115], TBL[v][114:99],
                  int'(TBL[v][98:96]), TBL[v][95:0], TBL[v][117:115] ^ 3'd1);
      end

      // R10: mode code switched to 5-6-5 while an indexed-4 word drains
      run_word("R10", 3'd1, 16'h1C70, 4, {24'h00FF00, 24'h778800, 24'hCC3300, 24'h11EE00}, 3'd4);

      // R7: back-to-back indexed-4 words, in_vld held high
      @(negedge clk);
      mode = 3'd1; in_word = 16'h1C70; in_vld = 1'b1;
      @(posedge clk);               // edge k
      @(negedge clk);
      in_word = 16'h0000;
      for (int j = 0; j < 9; j++) begin
         if (j > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         if (j < 4) chk("R7 in_rdy", {24'd0, in_rdy}, (j == 3) ? 25'd1 : 25'd0);
         if (j == 4) in_vld = 1'b0;
         if (j >= 1) begin
            logic [23:0] e;
            case (j)
               1: e = 24'h00FF00;
               2: e = 24'h778800;
               3: e = 24'hCC3300;
               4: e = 24'h11EE00;
               default: e = 24'h00FF00;
            endcase
            chk("R7/R8 stream", obs(), {1'b1, e});
         end
      end

      // R7: direct words, one per cycle
      @(negedge clk);
      mode = 3'd4; in_word = 16'h07E0; in_vld = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R7 direct in_rdy", {24'd0, in_rdy}, 25'd1);
      in_word = 16'hF81F;
      @(posedge clk);
      @(negedge clk);
      in_vld = 1'b0;
      chk("R7 direct p0", obs(), {1'b1, 24'h00FF00});
      @(posedge clk);
      @(negedge clk);
      chk("R7 direct p1", obs(), {1'b1, 24'hFF00FF});

      // R9: write red[0]=9, then a lookup of entry 0
      pal_write(2'd0, 8'h00, 4'h9);
      run_word("R9 write seen", 3'd1, 16'h0000, 4,
               {24'h99FF00, 24'h99FF00, 24'h99FF00, 24'h99FF00}, 3'd1);
      // R9: select 3 changes nothing
      pal_write(2'd3, 8'h00, 4'h5);
      run_word("R9 select 3 ignored", 3'd2, 16'h0000, 2,
               {24'h99FF00, 24'h99FF00, 48'd0}, 3'd2);

      // R11: unused code discarded
      @(negedge clk);
      mode = 3'd5; in_word = 16'h1234; in_vld = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_vld = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R11 no pixel", {23'd0, out_vld, in_rdy}, 25'd1);
         @(posedge clk);
         @(negedge clk);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule